// File: doc/BRIEF.md
# Expansion Bus Peripheral Target

This block is the card-side front end for an 8/16-bit expansion bus of the classic personal-computer kind. The bus host first shows an address with the address latch enable high. Later it lowers one of four active-low strobes: I/O read, I/O write, memory read or memory write. The block brings every bus input into its own clock through two flip-flops. It holds the address seen while the latch enable was high. It then checks whether that address falls inside one of two fixed windows: a small I/O port range and a memory range. Both bases are set by parameters, in the way a jumper block would set them.

On a read that hits, the block asks the local register file for a word with a single-cycle read pulse. It drives the captured word onto the data lines through an output enable, and it releases the lines once the strobe returns high. On a write that hits, it keeps the last data seen while the strobe was low. When the strobe rises it hands that word to the register file with a single-cycle write pulse. The I/O strobes and the memory strobes follow the same timing. Only the pair in use chooses the window that is checked.

Top module: `isa_target`

## Requirements
- R1: During and after reset, and before any bus cycle, `bus_data_oe`, `reg_rd` and `reg_wr` are low and `bus_data_out` is zero.
- R2: The address bus value is taken into the block while `bus_ale` is high and kept after it falls. Later changes on `bus_addr` do not move `reg_addr`. `reg_addr` is the low REG_AW bits of the held address.
- R3: An I/O cycle hits when bits [IO_SPACE_W-1:IO_WIN_W] of the held address equal the same bits of IO_BASE. Address bits at or above IO_SPACE_W take no part in the comparison.
- R4: A memory cycle hits when bits [ADDR_W-1:MEM_WIN_W] of the held address equal the same bits of MEM_BASE. This covers a 24-bit space by default.
- R5: On a read strobe falling with a hit, `reg_rd` pulses for exactly one cycle. One cycle later `bus_data_oe` rises and `bus_data_out` shows the `reg_rdata` word present during that pulse. The word is held unchanged while the output enable stays high.
- R6: `bus_data_oe` is low again three clock edges after the read strobe returns high.
- R7: On a write strobe rising with a hit, `reg_wr` pulses for exactly one cycle. `reg_wdata` then carries the last data value present before the strobe rose.
- R8: A strobe whose held address misses the window of its type gives no `reg_rd` or `reg_wr` pulse and never raises `bus_data_oe`.
- R9: `bus_data_oe` is never high during a write cycle.
- R10: `reg_is_mem` is 1 while `reg_rd` or `reg_wr` comes from a memory strobe and 0 while it comes from an I/O strobe. An address inside the memory window used with an I/O strobe is a miss, and the same holds the other way round.
- R11: Strobes change at a falling clock edge. `reg_rd` is high in the cycle after the second rising edge that follows the read strobe falling. `reg_wr` is high in the cycle after the second rising edge that follows the write strobe rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address lines |
| bus_ale | input | 1 | Address latch enable, active high |
| bus_ior_n | input | 1 | I/O read strobe, active low |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_memr_n | input | 1 | Memory read strobe, active low |
| bus_memw_n | input | 1 | Memory write strobe, active low |
| bus_data_in | input | DATA_W | Data lines as seen from the bus |
| bus_data_out | output | DATA_W | Data to drive onto the bus |
| bus_data_oe | output | 1 | Enable for the data line drivers |
| reg_addr | output | REG_AW | Register-file address |
| reg_is_mem | output | 1 | Current access came from the memory window |
| reg_wdata | output | DATA_W | Register-file write data |
| reg_wr | output | 1 | Register-file write pulse |
| reg_rd | output | 1 | Register-file read pulse |
| reg_rdata | input | DATA_W | Register-file read data |

## Verification
The properties assume that the host lowers only one strobe at a time and holds it low for several block clocks. They also assume that the latch enable is never high while a strobe is low, and that address and data are steady for at least two clocks around each edge they qualify. The bench keeps every cycle inside these limits. It raises the latch enable for three clocks and waits three more before lowering a strobe. It holds each strobe for six clocks and leaves idle time between cycles. After the latch enable falls, it moves the address lines on purpose, which shows that the held address is the one decoded.

// File: rtl/isa_target.sv
module isa_target #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int IO_SPACE_W = 16,
  parameter int IO_WIN_W   = 4,
  parameter int MEM_WIN_W  = 8,
  parameter logic [ADDR_W-1:0] IO_BASE  = 24'h000300,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h0D0000,
  localparam int REG_AW = (IO_WIN_W > MEM_WIN_W) ? IO_WIN_W : MEM_WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ale,
  input  logic              bus_ior_n,
  input  logic              bus_iow_n,
  input  logic              bus_memr_n,
  input  logic              bus_memw_n,
  input  logic [DATA_W-1:0] bus_data_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_data_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic              reg_is_mem,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata
);

  // control bits, active high: 4 ale, 3 io read, 2 io write, 1 mem read, 0 mem write
  logic [4:0]        c_m, c_s;
  logic [3:0]        c_p;
  logic [ADDR_W-1:0] a_m, a_s, lat;
  logic [DATA_W-1:0] d_m, d_s, wd, dq;
  logic              oe_q, io_hit, mem_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_m <= '0; c_s <= '0; c_p <= '0;
      a_m <= '0; a_s <= '0; d_m <= '0; d_s <= '0;
    end else begin
      c_m <= {bus_ale, ~bus_ior_n, ~bus_iow_n, ~bus_memr_n, ~bus_memw_n};
      c_s <= c_m;
      c_p <= c_s[3:0];
      a_m <= bus_addr;    a_s <= a_m;
      d_m <= bus_data_in; d_s <= d_m;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       lat <= '0;
    else if (c_s[4])  lat <= a_s;

  assign io_hit  = lat[IO_SPACE_W-1:IO_WIN_W] == IO_BASE[IO_SPACE_W-1:IO_WIN_W];
  assign mem_hit = lat[ADDR_W-1:MEM_WIN_W]    == MEM_BASE[ADDR_W-1:MEM_WIN_W];

  assign reg_rd = (c_s[3] & ~c_p[3] & io_hit) | (c_s[1] & ~c_p[1] & mem_hit);
  assign reg_wr = (~c_s[2] & c_p[2] & io_hit) | (~c_s[0] & c_p[0] & mem_hit);
  assign reg_is_mem = c_s[1] | c_s[0] | c_p[0];
  assign reg_addr   = lat[REG_AW-1:0];
  assign reg_wdata  = wd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                wd <= '0;
    else if (c_s[2] | c_s[0])  wd <= d_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oe_q <= 1'b0;
      dq   <= '0;
    end else begin
      oe_q <= (c_s[3] & io_hit) | (c_s[1] & mem_hit);
      if (reg_rd) dq <= reg_rdata;
    end

  assign bus_data_oe  = oe_q;
  assign bus_data_out = dq;

endmodule

module isa_target_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ale_s,
  input logic [ADDR_W-1:0] lat,
  input logic              wr_strobe_s,
  input logic              bus_data_oe,
  input logic [DATA_W-1:0] bus_data_out,
  input logic              reg_rd,
  input logic              reg_wr
);

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_s |=> $stable(lat));

  p_rd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_oe_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> bus_data_oe);

  p_data_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data_out));

  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_oe_off_in_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || wr_strobe_s) |-> !bus_data_oe);

  p_no_rd_with_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

endmodule

bind isa_target isa_target_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale_s(c_s[4]), .lat(lat),
  .wr_strobe_s(c_s[2] | c_s[0]),
  .bus_data_oe(bus_data_oe), .bus_data_out(bus_data_out),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/sim_isa_target.sv
module sim_isa_target;
  localparam int AW = 24, DW = 16, RAW = 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ale = 0, ior_n = 1, iow_n = 1, memr_n = 1, memw_n = 1;
  logic [DW-1:0] din = '0, dout, wdata, rdata;
  logic oe, wr, rd, is_mem;
  logic [RAW-1:0] raddr;

  always #5 clk = ~clk;

  isa_target u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_ale(ale),
    .bus_ior_n(ior_n), .bus_iow_n(iow_n), .bus_memr_n(memr_n), .bus_memw_n(memw_n),
    .bus_data_in(din), .bus_data_out(dout), .bus_data_oe(oe),
    .reg_addr(raddr), .reg_is_mem(is_mem), .reg_wdata(wdata),
    .reg_wr(wr), .reg_rd(rd), .reg_rdata(rdata));

  // downstream register file model: word depends on address and window
  assign rdata = {is_mem ? 8'hC3 : 8'h5A, raddr};

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
  bit oe_seen = 0, done = 0;

  always @(negedge clk) begin
    if (rd) rd_cnt++;
    if (wr) wr_cnt++;
    if (oe) oe_seen = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 io read, 1 io write, 2 mem read, 3 mem write
  task automatic strobe(input int kind, input logic v);
    case (kind)
      0: ior_n = v; 1: iow_n = v; 2: memr_n = v; default: memw_n = v;
    endcase
  endtask

  task automatic run(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit hit, input logic [DW-1:0] d2);
    int rc, wc;
    bit is_w, mem;
    is_w = kind[0]; mem = kind[1];
    @(negedge clk); addr = a; ale = 1;
    repeat (3) @(negedge clk);
    ale = 0;
    repeat (3) @(negedge clk);
    addr = ~a; din = d; oe_seen = 0;
    rc = rd_cnt; wc = wr_cnt;
    strobe(kind, 0);
    @(negedge clk); @(negedge clk);
    if (!is_w) begin
      chk("R11 read pulse timing", rd, hit);
      if (hit) begin
        chk("R2 held address", raddr, a[RAW-1:0]);
        chk("R10 window flag on read", is_mem, mem);
      end
      @(negedge clk);
      chk("R5 output enable on read", oe, hit);
      if (hit) chk("R5 read data", dout, {mem ? 8'hC3 : 8'h5A, a[7:0]});
      repeat (2) @(negedge clk);
      din = d2;
      repeat (1) @(negedge clk);
    end else begin
      repeat (2) @(negedge clk);
      din = d2;
      repeat (2) @(negedge clk);
    end
    strobe(kind, 1);
    @(negedge clk); @(negedge clk);
    if (is_w) begin
      chk("R11 write pulse timing", wr, hit);
      if (hit) begin
        chk("R7 write data", wdata, d2);
        chk("R2 held address on write", raddr, a[RAW-1:0]);
        chk("R10 window flag on write", is_mem, mem);
      end
    end
    @(negedge clk);
    chk("R6 enable released", oe, 0);
    repeat (3) @(negedge clk);
    chk("R5 R7 R8 pulse counts", {rd_cnt - rc, wr_cnt - wc},
        {(!is_w && hit) ? 1 : 0, (is_w && hit) ? 1 : 0});
    if (is_w) chk("R9 no drive in write", oe_seen, 0);
    else if (!hit) chk("R8 no drive on miss", oe_seen, 0);
  endtask

  localparam int NV = 12;
  // {kind[3:0], addr[23:0], data[15:0], hit[3:0]}
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 24'h000305, 16'hBEEF, 4'd1},  // R3 io write hit
    {4'd0, 24'h000305, 16'h0000, 4'd1},  // R3 io read hit
    {4'd0, 24'h0F030A, 16'h0000, 4'd1},  // R3 upper bits ignored
    {4'd1, 24'h000310, 16'h1111, 4'd0},  // R8 above io window
    {4'd0, 24'h0002FF, 16'h0000, 4'd0},  // R8 below io window
    {4'd3, 24'h0D0042, 16'h1234, 4'd1},  // R4 mem write hit
    {4'd2, 24'h0D00FF, 16'h0000, 4'd1},  // R4 mem read top
    {4'd2, 24'h0E0000, 16'h0000, 4'd0},  // R4 mem miss
    {4'd0, 24'h0D0003, 16'h0000, 4'd0},  // R10 mem address, io strobe
    {4'd3, 24'h000300, 16'h2222, 4'd0},  // R10 io address, mem strobe
    {4'd1, 24'h00030F, 16'h00A5, 4'd1},  // R3 top of io window
    {4'd2, 24'h0D0000, 16'h0000, 4'd1}   // R4 bottom of mem window
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset enable", oe, 0);
    chk("R1 reset pulses", {rd, wr}, 0);
    chk("R1 reset data", dout, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {oe, rd, wr}, 0);
    for (int i = 0; i < NV; i++)
      run(int'(VEC[i][47:44]), VEC[i][43:20], VEC[i][19:4], VEC[i][0], VEC[i][19:4]);
    // R7: data changed mid-strobe, last value wins
    run(1, 24'h000301, 16'h1111, 1, 16'h2222);
    run(3, 24'h0D0010, 16'h3333, 1, 16'h4444);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule